// File: doc/BRIEF.md
# Serial Transmit Framer with Sync Field

This block is the transmit side of a synchronous serial port. A start event, taken on a bit-clock enable cycle while the block is idle, opens a transfer. A programmable lead-in of bit periods follows, during which a synchronization pattern of programmable length can be sent least significant bit first. After the lead-in, a programmed number of data words go out back to back. Both the word length and the bit order are programmable.

Words come from an upstream source over a ready/valid handshake. Each word is requested one bit period before its first bit is due. If a word is missing at that point, a sticky underrun flag is raised and the idle level is sent in place of its bits.

Whenever no transfer is running, the line holds a programmable idle level. A one-cycle sync status pulse marks each accepted start event. The bit clock itself comes from outside as a one-cycle enable, and all configuration inputs are expected to be held steady during a transfer.

Top module: `tx_framer`

## Requirements
- R1: While `busy` is 0, `tx_data` equals `cfg_idle_lvl`, following a change of that input on the next clock.
- R2: A start is accepted only when `start` and `bit_en` are both 1 on the same clock edge while `busy` is 0. `tx_sync` is 1 for exactly the one clock after an accepted start and is 0 otherwise.
- R3: A `start` that arrives while `busy` is 1 has no effect: no `tx_sync` pulse, and the bit sequence on `tx_data` is unchanged.
- R4: Bit period p (p >= 1) is the value on `tx_data` after the p-th `bit_en` edge following the accepting edge; period 0 shows the idle level. For 1 <= p <= `cfg_start_dly`, period p carries `cfg_sync_pat[p-1]` when `cfg_sync_en` is 1 and p <= `cfg_sync_len`, and carries the idle level otherwise.
- R5: The first data bit is sent in period `cfg_start_dly`+1, including when `cfg_start_dly` is 0.
- R6: Words of L = `cfg_word_len`+1 bits are sent back to back, `cfg_word_cnt`+1 of them, with no gap. Only the low L bits of each word are used. The period after the last bit shows the idle level.
- R7: With `cfg_msb_first` = 1, bit L-1 of a word is sent first, down to bit 0. With `cfg_msb_first` = 0, bit 0 is sent first.
- R8: `word_ready` rises at the edge that begins the bit period before a word's first bit (period `cfg_start_dly` for the first word, the last bit period of the previous word for the others). A word is taken on an edge where `word_ready` and `word_valid` are both 1, and `word_ready` then falls.
- R9: If no word has been taken by the edge that begins that word, `underrun` becomes 1 and that word's bits are sent as the idle level. `underrun` stays 1 until the next accepted start clears it.
- R10: `busy` is 1 from the accepting edge up to the edge that ends the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle bit-clock enable; each high cycle ends one bit period |
| start | input | 1 | Start trigger, sampled with bit_en |
| cfg_idle_lvl | input | 1 | Level on the line outside transfers and for missing words |
| cfg_sync_en | input | 1 | Send the sync pattern during the lead-in |
| cfg_sync_len | input | 5 | Number of sync bits (0 to 16) |
| cfg_sync_pat | input | 16 | Sync pattern, sent LSB first |
| cfg_start_dly | input | 8 | Lead-in length in bit periods |
| cfg_word_len | input | 4 | Word length minus one |
| cfg_word_cnt | input | 4 | Words per start event minus one |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| word_data | input | 16 | Word offered by the source |
| word_valid | input | 1 | Source has a word |
| word_ready | output | 1 | Framer requests a word |
| tx_data | output | 1 | Serial data line |
| tx_sync | output | 1 | One-clock pulse on an accepted start event |
| underrun | output | 1 | Sticky flag: a word was missing when needed |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench sweeps idle level, sync enable and length, lead-in length (zero included), word length from one bit to the full width, word count, bit order and bit-clock spacing. For every combination it predicts each bit period arithmetically. A zero lead-in catches a design that fails to request the first word at the start edge, which would then report a false underrun. A sync length longer than the lead-in catches one that overruns into the data bits, and a one-bit word length catches a request that is skipped when one word's last bit is also its first. Starved words check that the idle level, and not stale data, fills the gap and that the flag clears only on the next start. Starts injected mid-transfer check that neither the sync pulse nor the bit stream is disturbed.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;

    // Sequencer phase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    // What the line carries in the bit period that a tick begins
    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_SYNC = 2'd1,
        LN_DATA = 2'd2
    } line_kind_e;

    // Per-tick command from the sequencer to the fetch and line stages
    typedef struct packed {
        line_kind_e kind;
        logic       word_start;   // tick begins bit 0 of a word
        logic       req_set;      // tick begins the period before a word
    } tick_cmd_t;

    // Bit position within a word for a given send index and order
    function automatic int unsigned bit_pos(input int unsigned idx,
                                            input int unsigned len_m1,
                                            input logic msb_first);
        return msb_first ? (len_m1 - idx) : idx;
    endfunction

endpackage

// File: rtl/tx_framer_seq.sv
module tx_framer_seq
    import tx_framer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SYNC_W = 16,
    parameter int DLY_W  = 8,
    parameter int CNT_W  = 4,
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int SIDX_W = $clog2(SYNC_W),
    localparam int SLEN_W = $clog2(SYNC_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              start,
    input  logic [DLY_W-1:0]  cfg_start_dly,
    input  logic              cfg_sync_en,
    input  logic [SLEN_W-1:0] cfg_sync_len,
    input  logic [BIT_W-1:0]  cfg_word_len,
    input  logic [CNT_W-1:0]  cfg_word_cnt,
    output tick_cmd_t         cmd,
    output logic [SIDX_W-1:0] sync_idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              start_acc,
    output logic              busy
);

    seq_state_e        state_q, state_d;
    logic [DLY_W-1:0]  dly_q, dly_d;
    logic [DLY_W-1:0]  lead_q, lead_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [CNT_W-1:0]  word_q, word_d;
    logic              acc;
    logic              in_field;
    logic              last_word;
    logic [CNT_W-1:0]  word_inc;
    logic [BIT_W-1:0]  bit_inc;

    // DLY_W is expected to be at least SLEN_W
    assign in_field  = cfg_sync_en && (lead_q < DLY_W'(cfg_sync_len));
    assign last_word = (word_q == cfg_word_cnt);
    assign word_inc  = word_q + CNT_W'(1);
    assign bit_inc   = bit_q + BIT_W'(1);
    assign sync_idx  = lead_q[SIDX_W-1:0];

    always_comb begin
        state_d        = state_q;
        dly_d          = dly_q;
        lead_d         = lead_q;
        bit_d          = bit_q;
        word_d         = word_q;
        acc            = 1'b0;
        bit_idx        = '0;
        cmd.kind       = LN_IDLE;
        cmd.word_start = 1'b0;
        cmd.req_set    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    acc         = 1'b1;
                    state_d     = ST_LEAD;
                    dly_d       = cfg_start_dly;
                    lead_d      = '0;
                    cmd.req_set = (cfg_start_dly == '0);
                end
            end
            ST_LEAD: begin
                if (dly_q == '0) begin
                    state_d        = ST_DATA;
                    bit_d          = '0;
                    word_d         = '0;
                    cmd.kind       = LN_DATA;
                    cmd.word_start = 1'b1;
                    cmd.req_set    = (cfg_word_len == '0) && (cfg_word_cnt != '0);
                end else begin
                    cmd.kind    = in_field ? LN_SYNC : LN_IDLE;
                    lead_d      = lead_q + DLY_W'(1);
                    dly_d       = dly_q - DLY_W'(1);
                    cmd.req_set = (dly_q == DLY_W'(1));
                end
            end
            ST_DATA: begin
                if (bit_q == cfg_word_len) begin
                    if (last_word) begin
                        state_d = ST_IDLE;
                    end else begin
                        word_d         = word_inc;
                        bit_d          = '0;
                        cmd.kind       = LN_DATA;
                        cmd.word_start = 1'b1;
                        cmd.req_set    = (cfg_word_len == '0) && (word_inc != cfg_word_cnt);
                    end
                end else begin
                    bit_d       = bit_inc;
                    bit_idx     = bit_inc;
                    cmd.kind    = LN_DATA;
                    cmd.req_set = (bit_inc == cfg_word_len) && !last_word;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dly_q   <= '0;
            lead_q  <= '0;
            bit_q   <= '0;
            word_q  <= '0;
        end else if (bit_en) begin
            state_q <= state_d;
            dly_q   <= dly_d;
            lead_q  <= lead_d;
            bit_q   <= bit_d;
            word_q  <= word_d;
        end
    end

    assign start_acc = acc && bit_en;
    assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/tx_framer_fetch.sv
module tx_framer_fetch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              word_start,
    input  logic              req_set,
    input  logic              start_acc,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              underrun,
    output logic [DATA_W-1:0] act_word,
    output logic              act_ok
);

    logic [DATA_W-1:0] hold_word;
    logic              hold_ok;
    logic [DATA_W-1:0] cur_word;
    logic              cur_ok;
    logic              take;
    logic              begin_word;
    logic [DATA_W-1:0] load_word;
    logic              load_ok;

    assign take       = word_ready && word_valid;
    assign begin_word = tick && word_start;
    assign load_word  = take ? word_data : hold_word;
    assign load_ok    = take || hold_ok;
    assign act_word   = begin_word ? load_word : cur_word;
    assign act_ok     = begin_word ? load_ok   : cur_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_word <= '0;
            hold_ok   <= 1'b0;
            cur_word  <= '0;
            cur_ok    <= 1'b0;
        end else if (begin_word) begin
            cur_word <= load_word;
            cur_ok   <= load_ok;
            hold_ok  <= 1'b0;
        end else if (take) begin
            hold_word <= word_data;
            hold_ok   <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_ready <= 1'b0;
        end else if (tick && req_set) begin
            word_ready <= 1'b1;
        end else if (take || begin_word) begin
            word_ready <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            underrun <= 1'b0;
        end else if (start_acc) begin
            underrun <= 1'b0;
        end else if (begin_word && !load_ok) begin
            underrun <= 1'b1;
        end
    end

endmodule

// File: rtl/tx_framer_line.sv
module tx_framer_line
    import tx_framer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SYNC_W = 16,
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int SIDX_W = $clog2(SYNC_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              busy,
    input  line_kind_e        kind,
    input  logic [SIDX_W-1:0] sync_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              cfg_idle_lvl,
    input  logic [SYNC_W-1:0] cfg_sync_pat,
    input  logic [BIT_W-1:0]  cfg_word_len,
    input  logic              cfg_msb_first,
    input  logic [DATA_W-1:0] act_word,
    input  logic              act_ok,
    output logic              tx_data
);

    logic [BIT_W-1:0] pos;
    logic             nxt_bit;

    assign pos = BIT_W'(bit_pos(int'(bit_idx), int'(cfg_word_len), cfg_msb_first));

    always_comb begin
        unique case (kind)
            LN_SYNC: nxt_bit = cfg_sync_pat[sync_idx];
            LN_DATA: nxt_bit = act_ok ? act_word[pos] : cfg_idle_lvl;
            default: nxt_bit = cfg_idle_lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= 1'b0;
        end else if (tick || !busy) begin
            tx_data <= nxt_bit;
        end
    end

endmodule

// File: rtl/tx_framer.sv
module tx_framer
    import tx_framer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SYNC_W = 16,
    parameter int DLY_W  = 8,
    parameter int CNT_W  = 4,
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int SIDX_W = $clog2(SYNC_W),
    localparam int SLEN_W = $clog2(SYNC_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              start,
    input  logic              cfg_idle_lvl,
    input  logic              cfg_sync_en,
    input  logic [SLEN_W-1:0] cfg_sync_len,
    input  logic [SYNC_W-1:0] cfg_sync_pat,
    input  logic [DLY_W-1:0]  cfg_start_dly,
    input  logic [BIT_W-1:0]  cfg_word_len,
    input  logic [CNT_W-1:0]  cfg_word_cnt,
    input  logic              cfg_msb_first,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              tx_data,
    output logic              tx_sync,
    output logic              underrun,
    output logic              busy
);

    tick_cmd_t         cmd;
    logic [SIDX_W-1:0] sync_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic              start_acc;
    logic [DATA_W-1:0] act_word;
    logic              act_ok;

    tx_framer_seq #(
        .DATA_W (DATA_W),
        .SYNC_W (SYNC_W),
        .DLY_W  (DLY_W),
        .CNT_W  (CNT_W)
    ) i_seq (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .start         (start),
        .cfg_start_dly (cfg_start_dly),
        .cfg_sync_en   (cfg_sync_en),
        .cfg_sync_len  (cfg_sync_len),
        .cfg_word_len  (cfg_word_len),
        .cfg_word_cnt  (cfg_word_cnt),
        .cmd           (cmd),
        .sync_idx      (sync_idx),
        .bit_idx       (bit_idx),
        .start_acc     (start_acc),
        .busy          (busy)
    );

    tx_framer_fetch #(
        .DATA_W (DATA_W)
    ) i_fetch (
        .clk        (clk),
        .rst        (rst),
        .tick       (bit_en),
        .word_start (cmd.word_start),
        .req_set    (cmd.req_set),
        .start_acc  (start_acc),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .underrun   (underrun),
        .act_word   (act_word),
        .act_ok     (act_ok)
    );

    tx_framer_line #(
        .DATA_W (DATA_W),
        .SYNC_W (SYNC_W)
    ) i_line (
        .clk           (clk),
        .rst           (rst),
        .tick          (bit_en),
        .busy          (busy),
        .kind          (cmd.kind),
        .sync_idx      (sync_idx),
        .bit_idx       (bit_idx),
        .cfg_idle_lvl  (cfg_idle_lvl),
        .cfg_sync_pat  (cfg_sync_pat),
        .cfg_word_len  (cfg_word_len),
        .cfg_msb_first (cfg_msb_first),
        .act_word      (act_word),
        .act_ok        (act_ok),
        .tx_data       (tx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sync <= 1'b0;
        end else begin
            tx_sync <= start_acc;
        end
    end

endmodule

// File: rtl/tx_framer_chk.sv
module tx_framer_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic start,
    input logic cfg_idle_lvl,
    input logic word_ready,
    input logic tx_data,
    input logic tx_sync,
    input logic underrun,
    input logic busy
);

    logic warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= 1'b0;
        end else begin
            warm <= 1'b1;
        end
    end

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        warm && !busy && $past(!busy) && $stable(cfg_idle_lvl) |-> tx_data == cfg_idle_lvl);

    // R2
    sync_origin_chk: assert property (@(posedge clk) disable iff (rst)
        tx_sync |-> $past(bit_en) && $past(start) && !$past(busy));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        busy && bit_en && start |=> !tx_sync);

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) && !$past(bit_en) |-> $stable(tx_data));

    // R8
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        word_ready |-> busy);

    // R9
    underrun_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(busy) && $past(bit_en));

endmodule

bind tx_framer tx_framer_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .start        (start),
    .cfg_idle_lvl (cfg_idle_lvl),
    .word_ready   (word_ready),
    .tx_data      (tx_data),
    .tx_sync      (tx_sync),
    .underrun     (underrun),
    .busy         (busy)
);

// File: tb/test_tx_framer.sv
module test_tx_framer;

    localparam int DATA_W = 16;
    localparam int SYNC_W = 16;
    localparam int DLY_W  = 8;
    localparam int CNT_W  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        start = 1'b0;
    logic        cfg_idle_lvl = 1'b0;
    logic        cfg_sync_en = 1'b0;
    logic [4:0]  cfg_sync_len = '0;
    logic [15:0] cfg_sync_pat = '0;
    logic [7:0]  cfg_start_dly = '0;
    logic [3:0]  cfg_word_len = '0;
    logic [3:0]  cfg_word_cnt = '0;
    logic        cfg_msb_first = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic        tx_data;
    logic        tx_sync;
    logic        underrun;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    // word server state
    int   serve_n = 0;
    logic srv_clr = 1'b0;
    logic starve_on = 1'b0;
    int   starve_k = -1;
    int   cur_t = 0;

    always #5 clk = ~clk;

    tx_framer #(
        .DATA_W (DATA_W),
        .SYNC_W (SYNC_W),
        .DLY_W  (DLY_W),
        .CNT_W  (CNT_W)
    ) i_tx_framer (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .start         (start),
        .cfg_idle_lvl  (cfg_idle_lvl),
        .cfg_sync_en   (cfg_sync_en),
        .cfg_sync_len  (cfg_sync_len),
        .cfg_sync_pat  (cfg_sync_pat),
        .cfg_start_dly (cfg_start_dly),
        .cfg_word_len  (cfg_word_len),
        .cfg_word_cnt  (cfg_word_cnt),
        .cfg_msb_first (cfg_msb_first),
        .word_data     (word_data),
        .word_valid    (word_valid),
        .word_ready    (word_ready),
        .tx_data       (tx_data),
        .tx_sync       (tx_sync),
        .underrun      (underrun),
        .busy          (busy)
    );

    function automatic logic [15:0] word_of(input int t, input int k);
        return 16'(32'h9B37 * (k + 1) + t * 32'h0F1D + 32'h5A);
    endfunction

    function automatic logic [15:0] sync_of(input int t);
        return 16'(32'hC3A5 ^ (t * 32'h1357));
    endfunction

    // one served word per request: taken, or missed at its start tick
    always @(posedge clk) begin
        if (srv_clr) serve_n <= 0;
        else if (word_ready && (word_valid || bit_en)) serve_n <= serve_n + 1;
    end

    always @(negedge clk) begin
        word_valid = word_ready && !(starve_on && serve_n == starve_k);
        word_data  = word_of(cur_t, serve_n);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one bit period: div clocks, bit_en high in the last one; returns at a negedge
    task automatic tick(input int div);
        for (int j = 1; j < div; j++) @(negedge clk);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic run_xfer(input int t, input int idle, input int sen, input int slen,
                            input int dly, input int len, input int cnt, input int msb,
                            input int div, input bit inject, input int sk);
        int          np;
        logic        exp_bit;
        logic        exp_rdy;
        logic [15:0] sp;
        logic [15:0] w;
        cur_t         = t;
        sp            = sync_of(t);
        cfg_idle_lvl  = idle[0];
        cfg_sync_en   = sen[0];
        cfg_sync_len  = 5'(slen);
        cfg_sync_pat  = sp;
        cfg_start_dly = 8'(dly);
        cfg_word_len  = 4'(len - 1);
        cfg_word_cnt  = 4'(cnt - 1);
        cfg_msb_first = msb[0];
        starve_on     = (sk >= 0);
        starve_k      = sk;
        srv_clr       = 1'b1;
        @(negedge clk);
        srv_clr       = 1'b0;
        @(negedge clk);
        check(tx_data == idle[0], "R1 idle level before start", int'(tx_data), idle);
        // start held through non-tick cycles; only the tick accepts it
        start = 1'b1;
        tick(div);
        start = 1'b0;
        check(tx_sync == 1'b1, "R2 sync pulse after start", int'(tx_sync), 1);
        check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        check(underrun == 1'b0, "R9 underrun cleared by start", int'(underrun), 0);
        check(word_ready == (dly == 0), "R8 ready at start", int'(word_ready), int'(dly == 0));
        check(tx_data == idle[0], "R4 period 0 idle", int'(tx_data), idle);
        @(negedge clk);
        check(tx_sync == 1'b0, "R2 sync pulse one clock", int'(tx_sync), 0);
        np = dly + len * cnt;
        for (int p = 1; p <= np + 1; p++) begin
            if (inject && p == 2) start = 1'b1;
            tick(div);
            start = 1'b0;
            if (p <= dly) begin
                exp_bit = (sen != 0 && p <= slen) ? sp[p-1] : idle[0];
                exp_rdy = (p == dly);
                check(tx_data == exp_bit, "R4 lead-in bit", int'(tx_data), int'(exp_bit));
            end else if (p <= np) begin
                int q = p - dly - 1;
                int k = q / len;
                int i = q % len;
                w = word_of(t, k);
                exp_bit = (sk == k) ? idle[0] : (msb != 0 ? w[len-1-i] : w[i]);
                exp_rdy = (i == len - 1) && (k != cnt - 1);
                if (p == dly + 1)
                    check(tx_data == exp_bit, "R5 first data bit", int'(tx_data), int'(exp_bit));
                else if (sk == k)
                    check(tx_data == exp_bit, "R9 missing word idle", int'(tx_data), int'(exp_bit));
                else if (msb != 0)
                    check(tx_data == exp_bit, "R7 msb-first bit", int'(tx_data), int'(exp_bit));
                else
                    check(tx_data == exp_bit, "R6 data bit", int'(tx_data), int'(exp_bit));
            end else begin
                exp_bit = idle[0];
                exp_rdy = 1'b0;
                check(tx_data == exp_bit, "R6 idle after last bit", int'(tx_data), int'(exp_bit));
            end
            check(word_ready == exp_rdy, "R8 word request", int'(word_ready), int'(exp_rdy));
            check(busy == (p <= np), "R10 busy span", int'(busy), int'(p <= np));
            if (inject && p == 2)
                check(tx_sync == 1'b0, "R3 start ignored while busy", int'(tx_sync), 0);
        end
        check(underrun == (sk >= 0), "R9 underrun flag", int'(underrun), int'(sk >= 0));
        // a late pulse from the injected start would show here
        check(busy == 1'b0, "R3 no restart", int'(busy), 0);
    endtask

    initial begin
        int t = 0;
        int slens[2] = '{3, 5};
        int dlys[3]  = '{0, 2, 6};
        int lens[4]  = '{1, 3, 8, 16};
        int cnts[2]  = '{1, 3};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R10 reset busy", int'(busy), 0);
        check(tx_sync == 1'b0, "R2 reset sync", int'(tx_sync), 0);
        check(word_ready == 1'b0, "R8 reset ready", int'(word_ready), 0);
        check(underrun == 1'b0, "R9 reset underrun", int'(underrun), 0);
        check(tx_data == 1'b0, "R1 reset idle level", int'(tx_data), 0);
        // idle level follows its control
        cfg_idle_lvl = 1'b1;
        @(negedge clk);
        check(tx_data == 1'b1, "R1 idle follows control", int'(tx_data), 1);
        // start without bit_en is not accepted
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R2 start needs bit_en", int'(busy), 0);
        check(tx_sync == 1'b0, "R2 no pulse without bit_en", int'(tx_sync), 0);
        for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
        for (int d = 0; d < 3; d++)
        for (int e = 0; e < 4; e++)
        for (int f = 0; f < 2; f++)
        for (int g = 0; g < 2; g++) begin
            int sk = (t % 4 == 1) ? (t % cnts[f]) : -1;
            run_xfer(t, a, b, slens[c], dlys[d], lens[e], cnts[f], g,
                     (t % 3) + 1, (t % 5 == 0), sk);
            t++;
        end
        // full-length sync field inside a longer lead-in
        run_xfer(t, 1, 1, 16, 18, 5, 2, 1, 2, 1'b1, -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule